// File: doc/BRIEF.md
# Block Copy and Compare Engine

This engine executes the string-style block operations of a processor core as a single memory-side state machine. A command supplies a source pointer, a destination pointer, an element count, an accumulator value and four mode bits: copy or compare, single or repeated, stepping up or down, and byte or word elements. The engine walks memory through a simple request/ready port and then reports the updated pointers, the remaining count and two flags.

A copy element reads one byte or one little-endian word at the source pointer and writes it to the destination pointer. A compare element reads at the source pointer and compares the value with the accumulator (its low byte in byte mode, all of it in word mode). Each element steps the pointers it used by the element size and takes one from the count. The repeated forms keep going until the count runs out. A repeated compare also stops as soon as an element matches.

Top module: `block_xfer_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `mem_req` and `mem_we` are low, and the result outputs are zero.
- R2: A single byte copy reads the byte at the source pointer and writes it to the destination pointer. It then raises both pointers by one and lowers the count by one.
- R3: When `cmd_down` is 1, both pointers of a copy drop by the element size after each element, instead of rising.
- R4: When `cmd_word` is 1, each element is one access with `mem_word` high. The access carries two bytes, little-endian (the byte at the pointer is in bits 7:0 and the byte at pointer+1 is in bits 15:8), and the pointers step by 2.
- R5: A repeated copy moves exactly `cmd_count` elements. It finishes with `res_count` = 0 and `flag_nonzero` = 0.
- R6: A compare reads at the source pointer and steps only that pointer; `res_dst` keeps its command value. `flag_match` is 1 when the value read equals the accumulator (only bits 7:0 count in byte mode) and 0 otherwise.
- R7: A repeated compare stops after the first matching element. It then reports `flag_match` = 1, and `flag_nonzero` is 1 exactly when the remaining count is non-zero.
- R8: A repeated compare that finds no match runs `cmd_count` elements. It ends with `flag_match` = 0, `flag_nonzero` = 0 and `res_count` = 0.
- R9: Pointers wrap modulo 2^24 in both directions.
- R10: `busy` is high from the cycle after a command is accepted until the result is ready. `done` is a single-cycle pulse with the results valid in that cycle. A `cmd_valid` seen while busy has no effect.
- R11: A copy element is a read handshake followed by a write handshake. A compare element is a read handshake only. `mem_req`, `mem_we` and `mem_addr` stay constant until `mem_ready`.
- R12: A single (non-repeated) operation issued with a count of 0 performs one element and reports `res_count` = 0xFFFF with `flag_nonzero` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_compare | input | 1 | 1 = compare, 0 = copy |
| cmd_repeat | input | 1 | 1 = repeat until count ends (or match) |
| cmd_down | input | 1 | 1 = pointers step down |
| cmd_word | input | 1 | 1 = word elements, 0 = byte |
| cmd_src | input | 24 | Source pointer |
| cmd_dst | input | 24 | Destination pointer |
| cmd_count | input | 16 | Element count |
| cmd_acc | input | 16 | Accumulator value for compare |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_src | output | 24 | Updated source pointer |
| res_dst | output | 24 | Updated destination pointer |
| res_count | output | 16 | Remaining count |
| flag_nonzero | output | 1 | Remaining count is non-zero |
| flag_match | output | 1 | Last compare matched |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request |
| mem_word | output | 1 | Access is a word |
| mem_addr | output | 24 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Completes the pending access |

## Verification
The assertions assume that the memory keeps `mem_ready` low when no request is pending. They also assume that it raises `mem_ready` for one cycle per access and never completes an access the engine has not asked for. The bench memory model keeps to this: it raises ready for one cycle only after a request has waited its programmed latency, and it drops ready in the next cycle. Commands are issued only while idle, except for one deliberate stray strobe during a run. Each command's expected pointers, count and flags are derived from a byte-array model of the memory.

// File: rtl/bt_pkg.sv
// Shared types for the block copy/compare engine.
// Assumes nothing beyond the parameter values chosen by the top.
package bt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bt_state_e;

    typedef struct packed {
        logic compare;
        logic rep;
        logic down;
        logic word;
    } bt_mode_t;
endpackage

// File: rtl/bt_ptr_step.sv
// Pointer stepper: moves a pointer up or down by one element.
// Assumes a word is DATA_W/8 bytes; wraps modulo 2^ADDR_W.
module bt_ptr_step #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic              down,
    input  logic              word,
    output logic [ADDR_W-1:0] nxt
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic [ADDR_W-1:0] step;

    // Pick the element size and apply it in the requested direction.
    always_comb begin
        step = word ? ADDR_W'(WORD_BYTES) : ADDR_W'(1);
        nxt  = down ? (ptr - step) : (ptr + step);
    end
endmodule

// File: rtl/bt_match.sv
// Lane-wise equality of read data against the accumulator.
// Assumes byte mode compares lane 0 only; word mode compares all lanes.
module bt_match #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              word,
    output logic              equal
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_eq;
    logic [LANES-1:0] lane_used;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // One comparator per byte lane; upper lanes count only for words.
        assign lane_eq[i]   = (lhs[8*i +: 8] == rhs[8*i +: 8]);
        assign lane_used[i] = (i == 0) ? 1'b1 : word;
    end

    // A lane that is not used cannot break the match.
    assign equal = &(lane_eq | ~lane_used);
endmodule

// File: rtl/bt_seq.sv
// Element sequencer: idle, read, optional write, and repeat decision.
// Assumes mem_ready is only high for a pending request, once per access.
module bt_seq
    import bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_compare,
    input  logic more,
    input  logic mem_ready,
    output logic busy,
    output logic mem_req,
    output logic mem_we,
    output logic read_ack,
    output logic elem_end,
    output logic done
);
    bt_state_e state_q, state_d;

    // Decode handshakes and the end of an element from the current state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_req  = busy;
        mem_we   = (state_q == ST_WRITE);
        read_ack = (state_q == ST_READ) && mem_ready;
        elem_end = (read_ack && is_compare) || ((state_q == ST_WRITE) && mem_ready);
    end

    // Next-state choice: write after a copy read, loop while more work remains.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  if (mem_ready) state_d = is_compare ? (more ? ST_READ : ST_IDLE) : ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = more ? ST_READ : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= elem_end && !more;
        end
    end

    // Request must hold its kind until the memory completes it.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));

    // A write may only begin right after a completed read.
    p_write_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_ready && !mem_we));

    // Completion is a lone pulse and coincides with idle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/block_xfer_engine.sv
// Block copy/compare engine top: holds the command, pointers, count,
// data latch and flags; the sequencer drives the memory handshakes.
// Assumes a memory that completes each request with a one-cycle mem_ready.
module block_xfer_engine
    import bt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_compare,
    input  logic              cmd_repeat,
    input  logic              cmd_down,
    input  logic              cmd_word,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [DATA_W-1:0] cmd_acc,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] res_src,
    output logic [ADDR_W-1:0] res_dst,
    output logic [CNT_W-1:0]  res_count,
    output logic              flag_nonzero,
    output logic              flag_match,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    bt_mode_t          mode_q;
    logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic [DATA_W-1:0] acc_q, data_q, rd_masked;
    logic              match_q, hit_now, more, start, read_ack, elem_end;

    // Accept a command only while idle; count and data shaping.
    always_comb begin
        start     = cmd_valid && !busy;
        cnt_nxt   = cnt_q - 1'b1;
        rd_masked = mode_q.word ? mem_rdata : DATA_W'(mem_rdata[7:0]);
        more      = mode_q.rep && (cnt_nxt != '0) && !(mode_q.compare && hit_now);
    end

    bt_ptr_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_src_step (
        .ptr(src_q), .down(mode_q.down), .word(mode_q.word), .nxt(src_nxt));
    bt_ptr_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dst_step (
        .ptr(dst_q), .down(mode_q.down), .word(mode_q.word), .nxt(dst_nxt));
    bt_match #(.DATA_W(DATA_W)) u_match (
        .lhs(mem_rdata), .rhs(acc_q), .word(mode_q.word), .equal(hit_now));

    bt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_compare(mode_q.compare),
        .more      (more),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .read_ack  (read_ack),
        .elem_end  (elem_end),
        .done      (done)
    );

    // Command capture, per-element pointer/count update and match flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
            data_q  <= '0;
            match_q <= 1'b0;
        end else if (start) begin
            mode_q  <= '{compare: cmd_compare, rep: cmd_repeat, down: cmd_down, word: cmd_word};
            src_q   <= cmd_src;
            dst_q   <= cmd_dst;
            cnt_q   <= cmd_count;
            acc_q   <= cmd_acc;
            match_q <= 1'b0;
        end else begin
            if (read_ack) data_q <= rd_masked;
            if (elem_end) begin
                src_q <= src_nxt;
                cnt_q <= cnt_nxt;
                if (mode_q.compare) match_q <= hit_now;
                else                dst_q   <= dst_nxt;
            end
        end
    end

    // Memory port and result outputs.
    always_comb begin
        mem_word     = mode_q.word;
        mem_addr     = mem_we ? dst_q : src_q;
        mem_wdata    = data_q;
        res_src      = src_q;
        res_dst      = dst_q;
        res_count    = cnt_q;
        flag_nonzero = (cnt_q != '0);
        flag_match   = match_q;
    end

    // A repeated copy only finishes once the count is used up.
    p_copy_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q.rep && !mode_q.compare) |-> !flag_nonzero);

    // A compare element leaves the destination pointer alone.
    p_cmp_keeps_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_end && mode_q.compare) |=> $stable(res_dst));

    // The address of a pending access holds until ready.
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    // A repeated compare that ends with count left must have matched.
    p_early_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q.rep && mode_q.compare && flag_nonzero) |-> flag_match);
endmodule

// File: tb/block_xfer_engine_bench.sv
// Scoreboard bench: a driver models each command on a shadow memory,
// pushes the expected result, and a monitor pops it on done.
module block_xfer_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_compare = 1'b0, cmd_repeat = 1'b0;
    logic        cmd_down = 1'b0, cmd_word = 1'b0;
    logic [23:0] cmd_src = '0, cmd_dst = '0;
    logic [15:0] cmd_count = '0, cmd_acc = '0;
    logic        busy, done, flag_nonzero, flag_match;
    logic [23:0] res_src, res_dst, mem_addr;
    logic [15:0] res_count, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, mem_word;
    logic        mem_ready = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_xfer_engine u_block_xfer_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_compare(cmd_compare),
        .cmd_repeat(cmd_repeat), .cmd_down(cmd_down), .cmd_word(cmd_word),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_count(cmd_count), .cmd_acc(cmd_acc),
        .busy(busy), .done(done), .res_src(res_src), .res_dst(res_dst),
        .res_count(res_count), .flag_nonzero(flag_nonzero), .flag_match(flag_match),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: byte array indexed by the low address byte.
    logic [7:0] mem [256];
    logic [7:0] sh  [256];
    int         lat = 0;
    int         wcnt = 0;
    int         n_rd = 0, n_wr = 0;
    logic [7:0] a0, a1;

    assign a0 = mem_addr[7:0];
    assign a1 = mem_addr[7:0] + 8'd1;
    assign mem_rdata = mem_word ? {mem[a1], mem[a0]} : {8'h00, mem[a0]};

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
            if (mem_we) begin
                n_wr++;
                mem[a0] <= mem_wdata[7:0];
                if (mem_word) mem[a1] <= mem_wdata[15:8];
            end else begin
                n_rd++;
            end
        end else if (mem_req) begin
            if (wcnt >= lat) mem_ready <= 1'b1;
            else wcnt <= wcnt + 1;
        end
    end

    typedef struct {
        string       tag;
        logic [23:0] src;
        logic [23:0] dst;
        logic [15:0] cnt;
        logic        nz;
        logic        z;
    } exp_t;

    exp_t exp_q[$];

    // Monitor: on each done pulse pop and compare; then check pulse width.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_src == e.src, e.tag, "res_src", 32'(res_src), 32'(e.src));
                check(res_dst == e.dst, e.tag, "res_dst", 32'(res_dst), 32'(e.dst));
                check(res_count == e.cnt, e.tag, "res_count", 32'(res_count), 32'(e.cnt));
                check(flag_nonzero == e.nz, e.tag, "flag_nonzero", 32'(flag_nonzero), 32'(e.nz));
                check(flag_match == e.z, e.tag, "flag_match", 32'(flag_match), 32'(e.z));
            end
            @(negedge clk);
            check(!done, "R10", "done width", 32'(done), 32'd0);
        end
    end

    // Driver: model the command on the shadow memory, push, issue, wait.
    task automatic run_cmd(input string tag, input bit cmp, input bit rep, input bit dn,
                           input bit wd, input logic [23:0] s, input logic [23:0] d,
                           input logic [15:0] c, input logic [15:0] acc,
                           input int latency, input bit stray);
        exp_t e;
        logic [23:0] ps = s, pd = d;
        logic [15:0] pc = c;
        logic [15:0] v;
        logic        z = 1'b0, hit;
        int          el = 0, rd0, wr0;
        logic [23:0] step = wd ? 24'd2 : 24'd1;
        forever begin
            v = wd ? {sh[ps[7:0] + 8'd1], sh[ps[7:0]]} : {8'h00, sh[ps[7:0]]};
            hit = wd ? (v == acc) : (v[7:0] == acc[7:0]);
            if (!cmp) begin
                sh[pd[7:0]] = v[7:0];
                if (wd) sh[pd[7:0] + 8'd1] = v[15:8];
                pd = dn ? pd - step : pd + step;
            end else begin
                z = hit;
            end
            ps = dn ? ps - step : ps + step;
            pc = pc - 16'd1;
            el++;
            if (!rep || pc == 16'd0 || (cmp && hit)) break;
        end
        e.tag = tag; e.src = ps; e.dst = pd; e.cnt = pc; e.nz = (pc != 0); e.z = z;
        exp_q.push_back(e);
        lat = latency;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        cmd_compare = cmp; cmd_repeat = rep; cmd_down = dn; cmd_word = wd;
        cmd_src = s; cmd_dst = d; cmd_count = c; cmd_acc = acc; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy, "R10", "busy after accept", 32'(busy), 32'd1);
        if (stray) begin
            // R10: a strobe while busy must not disturb the running command.
            cmd_src = 24'h000077; cmd_dst = 24'h000066; cmd_count = 16'd9;
            cmd_compare = 1'b1; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        check(n_rd - rd0 == el, "R11", "read handshakes", 32'(n_rd - rd0), 32'(el));
        check(n_wr - wr0 == (cmp ? 0 : el), "R11", "write handshakes",
              32'(n_wr - wr0), 32'(cmp ? 0 : el));
        @(negedge clk);
        check(!busy, "R10", "idle after done (stray ignored)", 32'(busy), 32'd0);
        for (int i = 0; i < 256; i++) begin
            if (mem[i] != sh[i]) begin
                check(1'b0, tag, $sformatf("memory byte %0d", i), 32'(mem[i]), 32'(sh[i]));
                break;
            end
        end
        checks++;
    endtask

    // Watchdog: a hung run counts as one failed check.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            sh[i]  = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", "busy/done in reset", {30'd0, busy, done}, 32'd0);
        check(!mem_req && !mem_we, "R1", "mem_req/we in reset", {30'd0, mem_req, mem_we}, 32'd0);
        check(res_src == 0 && res_count == 0 && !flag_match, "R1", "results in reset",
              32'(res_src), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 single byte copy up; R3 single byte copy down
        run_cmd("R2", 0, 0, 0, 0, 24'h000010, 24'h000080, 16'd5, 16'h0, 0, 0);
        run_cmd("R3", 0, 0, 1, 0, 24'h000020, 24'h000090, 16'd3, 16'h0, 2, 0);
        // R5 repeated byte copy up; R4 repeated word copy down
        run_cmd("R5", 0, 1, 0, 0, 24'h000030, 24'h0000A0, 16'd6, 16'h0, 1, 0);
        run_cmd("R4", 0, 1, 1, 1, 24'h000048, 24'h0000C8, 16'd4, 16'h0, 0, 0);
        // R6 single compares: byte hit, byte miss, word hit
        run_cmd("R6", 1, 0, 0, 0, 24'h000005, 24'h000123, 16'd2, {8'hEE, sh[5]}, 1, 0);
        run_cmd("R6", 1, 0, 0, 0, 24'h000005, 24'h000123, 16'd2, 16'h00FF ^ {8'h0, sh[5]}, 0, 0);
        run_cmd("R6", 1, 0, 1, 1, 24'h000060, 24'h000044, 16'd1, {sh[8'h61], sh[8'h60]}, 3, 0);
        // R7 repeated compare stops on the fourth element
        run_cmd("R7", 1, 1, 0, 0, 24'h000070, 24'h000000, 16'd10, {8'h00, sh[8'h73]}, 0, 0);
        // R8 repeated word compare without a match
        run_cmd("R8", 1, 1, 0, 1, 24'h0000D0, 24'h000000, 16'd5, 16'h0000, 1, 0);
        // R9 wrap upward on source, downward on destination
        run_cmd("R9", 0, 1, 0, 0, 24'hFFFFFE, 24'h000040, 16'd3, 16'h0, 0, 0);
        run_cmd("R9", 0, 1, 1, 1, 24'h000003, 24'h000001, 16'd2, 16'h0, 1, 0);
        // R12 single operation with count zero
        run_cmd("R12", 0, 0, 0, 0, 24'h000011, 24'h0000B0, 16'd0, 16'h0, 0, 0);
        // R10 stray strobe during a run
        run_cmd("R10", 0, 1, 0, 0, 24'h000018, 24'h0000E0, 16'd5, 16'h0, 2, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "all results seen", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule